// File: doc/BRIEF.md
# Pin-Change Interrupt Port

This block watches an eight-pin input port and turns chosen signal transitions into an interrupt request. Every pin has its own enable bit, its own polarity bit that picks a rising or a falling transition, and its own sticky flag bit. The pins are asynchronous to the block clock, so each one first crosses a synchronizer chain. A transition is then found by comparing the newest synchronized sample with the one before it. When the chosen transition appears, that pin's flag is set.

All the pins drive a single request output. The request is high while at least one pin has both its flag and its enable set. Servicing the request does not clear anything. Software reads the flag register to learn which pins fired, then writes that register to clear them. The same write can set flag bits, which lets software raise a request on purpose.

Software reaches the three registers through a single-cycle write strobe and a combinational read port. Reset is asynchronous and active low. Its release is synchronized inside the block. Transition detection stays masked until the synchronizer chain holds real pin samples, so a pin that is already high when reset ends does not report an edge.

Top module: `pcirq_port`

## Requirements
- R1: After reset the enable register (address 0), the polarity register (address 1) and the flag register (address 2) all read 0, and irq_o is 0.
- R2: With polarity bit 0, a low-to-high change on a pin sets that pin's flag bit, and a high-to-low change does not.
- R3: With polarity bit 1, a high-to-low change on a pin sets that pin's flag bit, and a low-to-high change does not. Each pin follows only its own polarity bit.
- R4: A flag bit is set by its transition even while the enable bit is 0, and irq_o stays 0. A later write of 1 to that enable bit makes irq_o read 1 at the next falling clock edge after that write.
- R5: irq_o is 1 exactly when some bit position is 1 in both the flag register and the enable register.
- R6: A flag bit stays set, with no further transitions, until software writes the flag register. A write to address 2 loads the written value, so 0 bits clear their flags.
- R7: If a flag-register write and a newly detected transition on a pin fall in the same clock cycle, that pin's flag ends up set, whatever value is written.
- R8: Writing 1s to the flag register sets those flags. This raises irq_o when a matching enable bit is set.
- R9: Register map: address 0 is the enable register, 1 is the polarity register and 2 is the flag register, with bit n belonging to pin n. Address 3 reads 0, and writes to it change no register.
- R10: Say a pin's new level is stable before rising clock edge k. Its flag reads set after edge k+2 and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous port pins |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register address for reads and writes |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational on addr_i |
| irq_o | output | 1 | Combined interrupt request for the port |

## Verification
Two events can land in the same clock edge: a software write to the flag register, and the flag update from a freshly detected transition. The bench changes a pin, counts the two synchronizer edges, and places a write to the flag register exactly on the edge where the transition is recognized. It does this once with a zero value and once with a different bit set. The flag register must then show the pin's bit set, combined with whatever bits the write itself set.

// File: rtl/pcirq_pkg.sv
`timescale 1ns/1ps
package pcirq_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_ENABLE   = 2'd0,
    REG_POLARITY = 2'd1,
    REG_FLAGS    = 2'd2,
    REG_SPARE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pcirq_rst_sync.sv
`timescale 1ns/1ps
// Reset asserts at once and is released on the clock.
module pcirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_no = shift_q[STAGES-1];
endmodule

// File: rtl/pcirq_pin_sync.sv
`timescale 1ns/1ps
// Per-pin synchronizer chain, a history sample, and the raw edge vectors.
module pcirq_pin_sync #(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] rise_o,
  output logic [N_PINS-1:0] fall_o
);
  localparam int unsigned ARM_W = SYNC_STAGES + 1;

  logic [N_PINS-1:0] level;
  logic [N_PINS-1:0] prev_q;
  logic [N_PINS-1:0] prev_d;
  logic [ARM_W-1:0]  arm_q;
  logic [ARM_W-1:0]  arm_d;
  logic              armed;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain_q;
    logic [SYNC_STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[SYNC_STAGES-2:0], pin_i[p]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign level[p] = chain_q[SYNC_STAGES-1];
  end

  // Edges count only once the history flop holds a real pin sample.
  always_comb begin
    prev_d = level;
    arm_d  = {arm_q[ARM_W-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      prev_q <= prev_d;
      arm_q  <= arm_d;
    end
  end

  assign armed  = arm_q[ARM_W-1];
  assign rise_o = armed ? (level & ~prev_q) : '0;
  assign fall_o = armed ? (~level & prev_q) : '0;
endmodule

// File: rtl/pcirq_flag_bank.sv
`timescale 1ns/1ps
// Enable, polarity and flag registers plus the combined request.
module pcirq_flag_bank
  import pcirq_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0]     wdata_i,
  input  logic [N_PINS-1:0]     rise_i,
  input  logic [N_PINS-1:0]     fall_i,
  output logic [N_PINS-1:0]     en_o,
  output logic [N_PINS-1:0]     pol_o,
  output logic [N_PINS-1:0]     flag_o,
  output logic [N_PINS-1:0]     hit_o,
  output logic                  irq_o
);
  logic [N_PINS-1:0] en_q,   en_d;
  logic [N_PINS-1:0] pol_q,  pol_d;
  logic [N_PINS-1:0] flag_q, flag_d;
  logic [N_PINS-1:0] hit;
  logic              en_ld, pol_ld, flag_ld;

  always_comb begin
    en_ld   = wr_en_i && (addr_i == REG_ENABLE);
    pol_ld  = wr_en_i && (addr_i == REG_POLARITY);
    flag_ld = wr_en_i && (addr_i == REG_FLAGS);
  end

  // Polarity 1 picks falling transitions, 0 picks rising ones.
  always_comb begin
    hit = (pol_q & fall_i) | (~pol_q & rise_i);
  end

  // A detected transition outranks a software write to the same bit.
  always_comb begin
    en_d   = en_ld  ? wdata_i : en_q;
    pol_d  = pol_ld ? wdata_i : pol_q;
    flag_d = (flag_ld ? wdata_i : flag_q) | hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= en_d;
      pol_q  <= pol_d;
      flag_q <= flag_d;
    end
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign flag_o = flag_q;
  assign hit_o  = hit;
  assign irq_o  = |(flag_q & en_q);
endmodule

// File: rtl/pcirq_port.sv
`timescale 1ns/1ps
module pcirq_port
  import pcirq_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_PINS-1:0]     pin_i,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0]     wdata_i,
  output logic [N_PINS-1:0]     rdata_o,
  output logic                  irq_o
);
  logic              rst_n_int;
  logic [N_PINS-1:0] rise;
  logic [N_PINS-1:0] fall;
  logic [N_PINS-1:0] en_q;
  logic [N_PINS-1:0] pol_q;
  logic [N_PINS-1:0] flag_q;
  logic [N_PINS-1:0] hit;

  pcirq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  pcirq_pin_sync #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  pcirq_flag_bank #(.N_PINS(N_PINS)) u_flag_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .en_o    (en_q),
    .pol_o   (pol_q),
    .flag_o  (flag_q),
    .hit_o   (hit),
    .irq_o   (irq_o)
  );

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_ENABLE:   rdata_o = en_q;
      REG_POLARITY: rdata_o = pol_q;
      REG_FLAGS:    rdata_o = flag_q;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pcirq_port_chk.sv
`timescale 1ns/1ps
module pcirq_port_chk
  import pcirq_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [N_PINS-1:0]     wdata,
  input logic [N_PINS-1:0]     en_q,
  input logic [N_PINS-1:0]     flag_q,
  input logic [N_PINS-1:0]     hit,
  input logic                  irq
);
  logic flag_wr;
  logic en_wr;
  assign flag_wr = wr_en && (addr == REG_FLAGS);
  assign en_wr   = wr_en && (addr == REG_ENABLE);

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_wr) |-> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_wr) |-> ((~flag_q & $past(flag_q)) == '0)); // R6
  AST_EDGE_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit) != '0) |-> (($past(hit) & ~flag_q) == '0)); // R7
  AST_SW_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_wr) |-> (($past(wdata) & ~flag_q) == '0)); // R8
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flag_q & en_q) != '0)); // R5
  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_wr) |-> (en_q == $past(wdata))); // R9
endmodule

bind pcirq_port pcirq_port_chk #(.N_PINS(N_PINS)) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_n_int),
  .wr_en  (wr_en_i),
  .addr   (addr_i),
  .wdata  (wdata_i),
  .en_q   (en_q),
  .flag_q (flag_q),
  .hit    (hit),
  .irq    (irq_o)
);

// File: tb/pcirq_port_tb.sv
`timescale 1ns/1ps
module pcirq_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'h00;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pcirq_port u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .pin_i   (pins),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // Changes the pins, then waits three rising edges so the flag has settled.
  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] expf;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 enable", v, 8'h00);
    rd(2'd1, v); check("R1 polarity", v, 8'h00);
    rd(2'd2, v); check("R1 flags", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2/R3 sweep over every pin and both polarities, enables off (R4)
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd1, pol ? 8'hFF : 8'h00);
      for (int b = 0; b < 8; b++) begin
        wr(2'd2, 8'h00);
        drive(8'h01 << b);
        rd(2'd2, v);
        expf = (pol == 0) ? (8'h01 << b) : 8'h00;
        check(pol ? "R3 rise ignored" : "R2 rise sets", v, expf);
        check("R4 irq low while disabled", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h00);
        drive(8'h00);
        rd(2'd2, v);
        expf = (pol == 1) ? (8'h01 << b) : 8'h00;
        check(pol ? "R3 fall sets" : "R2 fall ignored", v, expf);
      end
    end

    // R3 mixed per-pin polarity
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h00);
    drive(8'hFF);
    rd(2'd2, v); check("R3 mixed rise", v, 8'h5A);
    drive(8'h00);
    rd(2'd2, v); check("R3 mixed fall", v, 8'hFF);

    // R6 sticky, then partial clear by written value
    repeat (5) @(negedge clk);
    rd(2'd2, v); check("R6 sticky", v, 8'hFF);
    wr(2'd2, 8'hF0);
    rd(2'd2, v); check("R6 write loads", v, 8'hF0);

    // R4 enabling later raises the request at once, R5 overlap rule
    wr(2'd0, 8'h0F);
    check("R5 disjoint irq", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h10);
    check("R4 enable raises irq", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    check("R5 cleared irq", {7'd0, irq}, 8'h00);

    // R10 latency: rising edge with polarity 0
    wr(2'd1, 8'h00);
    @(negedge clk);
    pins = 8'h04;
    repeat (2) @(negedge clk);
    rd(2'd2, v); check("R10 not after k+1", v, 8'h00);
    @(negedge clk);
    rd(2'd2, v); check("R10 set after k+2", v, 8'h04);

    // R7 write collides with detection edge
    wr(2'd2, 8'h00);
    @(negedge clk);
    pins = 8'h05;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd2, v); check("R7 edge wins over clear", v, 8'h01);
    wr(2'd2, 8'h00);
    @(negedge clk);
    pins = 8'h07;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h10;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd2, v); check("R7 edge merges with write", v, 8'h12);

    // R8 software-set flag raises request
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h80);
    check("R8 irq before set", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h80);
    check("R8 software irq", {7'd0, irq}, 8'h01);

    // R9 spare address
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R9 spare reads 0", v, 8'h00);
    rd(2'd0, v); check("R9 enable untouched", v, 8'h80);
    rd(2'd1, v); check("R9 polarity untouched", v, 8'h00);
    rd(2'd2, v); check("R9 flags untouched", v, 8'h80);

    finish_run();
  end
endmodule